// File: doc/BRIEF.md
# Hybrid SRAM / STT-RAM Data Cache Controller

This block is a data cache built from two physically separate set-associative partitions: a small, fast SRAM partition and a larger STT-RAM partition whose writes are much slower than its reads. Each lookup searches both partitions in parallel, and a hit is served from whichever partition holds the line. The cache never chooses a placement on its own. Each request carries a partition-select bit, and that bit names the destination only when a line has to be installed: a read miss that brings a line in from memory, or a line-wide write arriving from the level above that finds no copy. Once a line sits in a partition it stays there until it is evicted. It never moves to the other partition.

Both sides use valid/ready handshakes. On the upstream side a request is accepted when `req_valid` and `req_ready` are both high. The block then holds `req_ready` low until the matching response has been taken, so requests complete strictly one at a time and in order. A response, or a memory request, is held unchanged for as long as the receiver keeps its ready low. Memory refills come back on a separate response channel. Each partition replaces lines by LRU within its set. A dirty victim is written to memory before the new line takes its slot.

Top module: `hybrid_cache`

## Requirements
- R1: A read probes both partitions and ignores `req_to_nvm`. When either partition holds the line, the response carries `rsp_hit`=1, `rsp_in_nvm` naming the holder (0 = SRAM, 1 = STT-RAM) and the stored line. `rsp_valid` rises exactly LOOK cycles after acceptance, where LOOK is the larger of the two read latencies (3 by default).
- R2: A read miss fetches the line from memory with a read request. It installs the line clean into the partition named by `req_to_nvm` (0 = SRAM, 1 = STT-RAM) and responds with `rsp_hit`=0, `rsp_in_nvm` equal to the select and the fetched data.
- R3: A write that hits updates the line in place in the partition that holds it, marks it dirty and ignores `req_to_nvm`. The response comes LOOK plus that partition's write latency cycles after acceptance: 6 for SRAM and 13 for STT-RAM by default.
- R4: A write that misses installs the written line, marked dirty, into the selected partition. It issues no memory read, and the response carries the written line with `rsp_hit`=0.
- R5: A line is never moved between partitions and is never held by both partitions at once.
- R6: Within a set, each partition takes an invalid way first. Otherwise it evicts the least recently used way, where both hits and installs count as uses.
- R7: Before a dirty victim is overwritten, it is sent to memory as a write request carrying the victim's line address and data. A clean victim is dropped without any memory traffic.
- R8: `req_ready` is low from the cycle after a request is accepted until its response has been taken, including for the whole duration of a long STT-RAM write.
- R9: While `rsp_ready` is low, `rsp_valid` and `rsp_data` hold their values. While `mem_req_ready` is low, `mem_req_valid`, `mem_req_write` and `mem_req_addr` hold their values.
- R10: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0, and every line in both partitions is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = line-wide write from above, 0 = read |
| req_addr | input | ADDR_W | Line address |
| req_data | input | LINE_W | Line to write |
| req_to_nvm | input | 1 | Install target on a miss: 0 = SRAM, 1 = STT-RAM |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Upstream takes the response |
| rsp_data | output | LINE_W | Line read, or line written |
| rsp_hit | output | 1 | Request hit in either partition |
| rsp_in_nvm | output | 1 | Partition holding the line after the request |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write-back of a victim, 0 = line fetch |
| mem_req_addr | output | ADDR_W | Line address for the memory request |
| mem_req_data | output | LINE_W | Victim data for a write-back |
| mem_rsp_valid | input | 1 | Fetched line valid |
| mem_rsp_ready | output | 1 | Block takes the fetched line |
| mem_rsp_data | input | LINE_W | Fetched line |

## Verification
The bench builds the block with 8-bit line addresses and 2-byte lines. It uses two sets of two ways in the SRAM partition and four sets of two ways in the STT-RAM partition, so a handful of requests to addresses that share a low bit fill a set and force LRU evictions of both clean and dirty lines in each partition. The latencies stay at their defaults, which lets the 3-, 6- and 13-cycle response timing for read hits, SRAM write hits and STT-RAM write hits be checked exactly. The memory model keeps every written-back line, so a line evicted dirty and then read again into the other partition proves that the write-back reached memory and that no line migrates directly.

// File: rtl/hyc_pkg.sv
package hyc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_FETCH,
    ST_FILL,
    ST_WRITE,
    ST_RESP
  } hyc_state_e;

  typedef enum logic {
    PART_SRAM = 1'b0,
    PART_NVM  = 1'b1
  } hyc_part_e;

endpackage

// File: rtl/hyc_victim.sv
module hyc_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]             valid,
  input  logic [WAYS-1:0][WAY_W-1:0]  age,
  output logic [WAY_W-1:0]            way
);

  logic found;

  always_comb begin
    way   = '0;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid[w] && !found) begin
        way   = WAY_W'(w);
        found = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age[w] == WAY_W'(WAYS - 1)) way = WAY_W'(w);
      end
    end
  end

endmodule

// File: rtl/hyc_part.sv
module hyc_part #(
  parameter int ADDR_W = 26,
  parameter int LINE_W = 512,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              touch,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [LINE_W-1:0] wr_data,
  input  logic              wr_dirty,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic [LINE_W-1:0] hit_data,
  output logic [WAY_W-1:0]  vic_way,
  output logic              vic_dirty,
  output logic [ADDR_W-1:0] vic_addr,
  output logic [LINE_W-1:0] vic_data
);

  logic [TAG_W-1:0]            tag_q   [SETS][WAYS];
  logic [LINE_W-1:0]           data_q  [SETS][WAYS];
  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0]             dirty_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0]  age_q   [SETS];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [WAYS-1:0]  way_hit;
  logic [WAYS-1:0]  oldest;
  logic [WAY_W-1:0] upd_way;
  logic             upd;

  assign idx = lk_addr[IDX_W-1:0];
  assign tag = lk_addr[ADDR_W-1:IDX_W];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign way_hit[g] = valid_q[idx][g] && (tag_q[idx][g] == tag);
    assign oldest[g]  = (age_q[idx][g] == WAY_W'(WAYS - 1));
  end

  assign hit = |way_hit;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit_data = data_q[idx][hit_way];

  hyc_victim #(.WAYS(WAYS)) u_victim (
    .valid (valid_q[idx]),
    .age   (age_q[idx]),
    .way   (vic_way)
  );

  assign vic_dirty = valid_q[idx][vic_way] && dirty_q[idx][vic_way];
  assign vic_addr  = {tag_q[idx][vic_way], idx};
  assign vic_data  = data_q[idx][vic_way];

  assign upd     = wr_en | touch;
  assign upd_way = wr_en ? wr_way : hit_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else begin
      if (wr_en) begin
        valid_q[idx][wr_way] <= 1'b1;
        dirty_q[idx][wr_way] <= wr_dirty;
      end
      if (upd) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == upd_way) age_q[idx][w] <= '0;
          else if (age_q[idx][w] < age_q[idx][upd_way])
            age_q[idx][w] <= age_q[idx][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[idx][wr_way]  <= tag;
      data_q[idx][wr_way] <= wr_data;
    end
  end

  AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1) else $error("LRU ages lost order"); // R6

  AST_HIT_WRITE_IN_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit) |-> (wr_way == hit_way)) else $error("hit line written to wrong way"); // R5

endmodule

// File: rtl/hybrid_cache.sv
module hybrid_cache
  import hyc_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 64,
  parameter int S_BYTES    = 4096,
  parameter int S_WAYS     = 4,
  parameter int S_RD_LAT   = 3,
  parameter int S_WR_LAT   = 3,
  parameter int N_BYTES    = 65536,
  parameter int N_WAYS     = 4,
  parameter int N_RD_LAT   = 3,
  parameter int N_WR_LAT   = 10,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LINE_W-1:0] req_data,
  input  logic              req_to_nvm,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [LINE_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              rsp_in_nvm,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0] mem_req_data,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [LINE_W-1:0] mem_rsp_data
);

  localparam int S_SETS  = S_BYTES / LINE_BYTES / S_WAYS;
  localparam int N_SETS  = N_BYTES / LINE_BYTES / N_WAYS;
  localparam int S_WAY_W = (S_WAYS > 1) ? $clog2(S_WAYS) : 1;
  localparam int N_WAY_W = (N_WAYS > 1) ? $clog2(N_WAYS) : 1;
  localparam int WAY_W   = (S_WAY_W > N_WAY_W) ? S_WAY_W : N_WAY_W;
  localparam int LK_LAT  = (S_RD_LAT > N_RD_LAT) ? S_RD_LAT : N_RD_LAT;
  localparam int WR_MAX  = (S_WR_LAT > N_WR_LAT) ? S_WR_LAT : N_WR_LAT;
  localparam int LAT_MAX = (LK_LAT > WR_MAX) ? LK_LAT : WR_MAX;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  hyc_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              op_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] line_q;
  hyc_part_e         sel_q;
  hyc_part_e         tgt_q;
  logic [WAY_W-1:0]  way_q;
  logic              hit_q;
  logic              wdirty_q;

  logic               s_hit, n_hit;
  logic [S_WAY_W-1:0] s_hit_way, s_vic_way;
  logic [N_WAY_W-1:0] n_hit_way, n_vic_way;
  logic [LINE_W-1:0]  s_hit_data, n_hit_data, s_vic_data, n_vic_data;
  logic               s_vic_dirty, n_vic_dirty;
  logic [ADDR_W-1:0]  s_vic_addr, n_vic_addr;

  logic              look_last, wr_last;
  logic [CNT_W-1:0]  wr_lat;
  logic              s_touch, n_touch, s_wr, n_wr;
  logic              sel_vic_dirty;
  logic [WAY_W-1:0]  sel_vic_way;

  assign look_last = (state_q == ST_LOOK) && (cnt_q == CNT_W'(LK_LAT - 1));
  assign wr_lat    = (tgt_q == PART_NVM) ? CNT_W'(N_WR_LAT) : CNT_W'(S_WR_LAT);
  assign wr_last   = (state_q == ST_WRITE) && (cnt_q == wr_lat - 1'b1);

  assign s_touch = look_last && !op_wr_q && s_hit;
  assign n_touch = look_last && !op_wr_q && n_hit && !s_hit;
  assign s_wr    = wr_last && (tgt_q == PART_SRAM);
  assign n_wr    = wr_last && (tgt_q == PART_NVM);

  assign sel_vic_dirty = (sel_q == PART_NVM) ? n_vic_dirty : s_vic_dirty;
  assign sel_vic_way   = (sel_q == PART_NVM) ? WAY_W'(n_vic_way) : WAY_W'(s_vic_way);

  hyc_part #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W),
    .SETS   (S_SETS),
    .WAYS   (S_WAYS)
  ) u_sram (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_addr   (addr_q),
    .touch     (s_touch),
    .wr_en     (s_wr),
    .wr_way    (way_q[S_WAY_W-1:0]),
    .wr_data   (line_q),
    .wr_dirty  (wdirty_q),
    .hit       (s_hit),
    .hit_way   (s_hit_way),
    .hit_data  (s_hit_data),
    .vic_way   (s_vic_way),
    .vic_dirty (s_vic_dirty),
    .vic_addr  (s_vic_addr),
    .vic_data  (s_vic_data)
  );

  hyc_part #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W),
    .SETS   (N_SETS),
    .WAYS   (N_WAYS)
  ) u_nvm (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_addr   (addr_q),
    .touch     (n_touch),
    .wr_en     (n_wr),
    .wr_way    (way_q[N_WAY_W-1:0]),
    .wr_data   (line_q),
    .wr_dirty  (wdirty_q),
    .hit       (n_hit),
    .hit_way   (n_hit_way),
    .hit_data  (n_hit_data),
    .vic_way   (n_vic_way),
    .vic_dirty (n_vic_dirty),
    .vic_addr  (n_vic_addr),
    .vic_data  (n_vic_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      op_wr_q  <= 1'b0;
      addr_q   <= '0;
      line_q   <= '0;
      sel_q    <= PART_SRAM;
      tgt_q    <= PART_SRAM;
      way_q    <= '0;
      hit_q    <= 1'b0;
      wdirty_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q <= ST_LOOK;
            cnt_q   <= '0;
            op_wr_q <= req_write;
            addr_q  <= req_addr;
            line_q  <= req_data;
            sel_q   <= hyc_part_e'(req_to_nvm);
          end
        end
        ST_LOOK: begin
          if (look_last) begin
            cnt_q <= '0;
            if (s_hit || n_hit) begin
              hit_q <= 1'b1;
              tgt_q <= s_hit ? PART_SRAM : PART_NVM;
              way_q <= s_hit ? WAY_W'(s_hit_way) : WAY_W'(n_hit_way);
              if (op_wr_q) begin
                wdirty_q <= 1'b1;
                state_q  <= ST_WRITE;
              end else begin
                line_q  <= s_hit ? s_hit_data : n_hit_data;
                state_q <= ST_RESP;
              end
            end else begin
              hit_q    <= 1'b0;
              tgt_q    <= sel_q;
              way_q    <= sel_vic_way;
              wdirty_q <= op_wr_q;
              if (sel_vic_dirty)  state_q <= ST_EVICT;
              else if (op_wr_q)   state_q <= ST_WRITE;
              else                state_q <= ST_FETCH;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_EVICT: begin
          if (mem_req_ready) state_q <= op_wr_q ? ST_WRITE : ST_FETCH;
        end
        ST_FETCH: begin
          if (mem_req_ready) state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (mem_rsp_valid) begin
            line_q  <= mem_rsp_data;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wr_last) state_q <= ST_RESP;
          else         cnt_q   <= cnt_q + 1'b1;
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_data      = line_q;
  assign rsp_hit       = hit_q;
  assign rsp_in_nvm    = (tgt_q == PART_NVM);
  assign mem_req_valid = (state_q == ST_EVICT) || (state_q == ST_FETCH);
  assign mem_req_write = (state_q == ST_EVICT);
  assign mem_req_addr  = (state_q == ST_EVICT) ?
                         ((tgt_q == PART_NVM) ? n_vic_addr : s_vic_addr) : addr_q;
  assign mem_req_data  = (tgt_q == PART_NVM) ? n_vic_data : s_vic_data;
  assign mem_rsp_ready = (state_q == ST_FILL);

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready) else $error("second request accepted"); // R8

  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))) else $error("response dropped"); // R9

  AST_MEM_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))) else $error("memory request dropped"); // R9

  AST_SINGLE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wr || n_wr) |=> !(s_hit && n_hit)) else $error("line present in both partitions"); // R5

  AST_NO_CROSS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_wr && n_hit) || (n_wr && s_hit)) == 1'b0) else $error("line written away from its home"); // R5

  AST_PLACE_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
    s_wr |-> (s_hit || sel_q == PART_SRAM)) else $error("SRAM install not selected"); // R2

  AST_PLACE_NVM: assert property (@(posedge clk) disable iff (!rst_n)
    n_wr |-> (n_hit || sel_q == PART_NVM)) else $error("STT-RAM install not selected"); // R4

endmodule

// File: tb/tb_hybrid_cache.sv
`timescale 1ns/1ps
module tb_hybrid_cache;

  localparam int AW = 8;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_data = '0;
  logic          req_to_nvm = 1'b0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [LW-1:0] rsp_data;
  logic          rsp_hit;
  logic          rsp_in_nvm;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic          mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [LW-1:0] mem_req_data;
  logic          mem_rsp_valid = 1'b0;
  logic          mem_rsp_ready;
  logic [LW-1:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  int wb_cnt = 0;
  int mem_delay = 0;
  logic [LW-1:0] mem [256];

  always #2 clk = ~clk;

  hybrid_cache #(
    .ADDR_W(AW), .LINE_BYTES(2),
    .S_BYTES(8),  .S_WAYS(2),
    .N_BYTES(16), .N_WAYS(2)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data), .req_to_nvm(req_to_nvm),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_hit(rsp_hit), .rsp_in_nvm(rsp_in_nvm),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_data(mem_req_data), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  // {wr, addr, sel, wdata, exp_hit, exp_nvm, exp_data, exp_lat (0 = not checked)}
  localparam int NV = 20;
  localparam logic [51:0] VEC [NV] = '{
    {1'b0, 8'h10, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h10EF, 8'd0},   // R2 miss into SRAM
    {1'b0, 8'h10, 1'b1, 16'h0000, 1'b1, 1'b0, 16'h10EF, 8'd3},   // R1 select ignored
    {1'b0, 8'h21, 1'b1, 16'h0000, 1'b0, 1'b1, 16'h21DE, 8'd0},   // R2 miss into STT-RAM
    {1'b0, 8'h21, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h21DE, 8'd3},   // R1
    {1'b1, 8'h10, 1'b1, 16'hAAAA, 1'b1, 1'b0, 16'hAAAA, 8'd6},   // R3 SRAM write hit
    {1'b0, 8'h10, 1'b1, 16'h0000, 1'b1, 1'b0, 16'hAAAA, 8'd3},   // R5 stays in SRAM
    {1'b1, 8'h21, 1'b0, 16'hBBBB, 1'b1, 1'b1, 16'hBBBB, 8'd13},  // R3 STT-RAM write hit
    {1'b0, 8'h21, 1'b0, 16'h0000, 1'b1, 1'b1, 16'hBBBB, 8'd3},   // R1
    {1'b1, 8'h30, 1'b1, 16'hCCCC, 1'b0, 1'b1, 16'hCCCC, 8'd13},  // R4 write miss, no fetch
    {1'b0, 8'h30, 1'b0, 16'h0000, 1'b1, 1'b1, 16'hCCCC, 8'd3},   // R1
    {1'b0, 8'h12, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h12ED, 8'd0},   // R6 invalid way first
    {1'b0, 8'h14, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h14EB, 8'd0},   // R7 evicts dirty 0x10
    {1'b0, 8'h10, 1'b1, 16'h0000, 1'b0, 1'b1, 16'hAAAA, 8'd0},   // R7 write-back reached memory
    {1'b0, 8'h10, 1'b0, 16'h0000, 1'b1, 1'b1, 16'hAAAA, 8'd3},   // R1
    {1'b0, 8'h12, 1'b1, 16'h0000, 1'b1, 1'b0, 16'h12ED, 8'd3},   // R6 LRU kept 0x12
    {1'b0, 8'h16, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h16E9, 8'd0},   // R7 clean victim 0x14
    {1'b0, 8'h14, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h14EB, 8'd0},   // R7 clean victim 0x12
    {1'b0, 8'h34, 1'b1, 16'h0000, 1'b0, 1'b1, 16'h34CB, 8'd0},   // R7 evicts dirty 0x30
    {1'b0, 8'h30, 1'b0, 16'h0000, 1'b0, 1'b0, 16'hCCCC, 8'd0},   // R5 refetched, not moved
    {1'b1, 8'h11, 1'b0, 16'hDDDD, 1'b0, 1'b0, 16'hDDDD, 8'd6}    // R4 SRAM write miss
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic s,
                       input logic [LW-1:0] wd, input int hold,
                       output logic [LW-1:0] d, output logic h, output logic n,
                       output int lat, output logic busy_ready, output logic hold_bad);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_to_nvm = s; req_data = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0; busy_ready = 1'b0; hold_bad = 1'b0;
    while (!rsp_valid) begin
      if (req_ready) busy_ready = 1'b1;
      lat++;
      @(negedge clk);
    end
    d = rsp_data; h = rsp_hit; n = rsp_in_nvm;
    if (hold > 0) begin
      rsp_ready = 1'b0;
      repeat (hold) begin
        @(negedge clk);
        if (!rsp_valid || rsp_data !== d) hold_bad = 1'b1;
      end
      rsp_ready = 1'b1;
    end
  endtask

  // memory model
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {8'(i), ~8'(i)};
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic          w;
        logic [AW-1:0] ma;
        logic [LW-1:0] md;
        repeat (mem_delay) @(negedge clk);
        mem_req_ready = 1'b1;
        w = mem_req_write; ma = mem_req_addr; md = mem_req_data;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (w) begin
          mem[ma] = md;
          wb_cnt++;
        end else begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem[ma];
          while (!mem_rsp_ready) @(negedge clk);
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [LW-1:0] d;
    logic h, n, br, hb;
    int lat;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "req_ready", 32'(req_ready), 32'd1);
    chk("R10", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R10", "mem_req_valid", 32'(mem_req_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [51:0] v;
      string tag;
      v = VEC[i];
      tag = v[25] ? (v[51] ? "R3" : "R1") : (v[51] ? "R4" : "R2");
      do_op(v[51], v[50:43], v[42], v[41:26], 0, d, h, n, lat, br, hb);
      chk(tag, $sformatf("vec%0d data", i), 32'(d), 32'(v[23:8]));
      chk(tag, $sformatf("vec%0d hit", i), 32'(h), 32'(v[25]));
      chk(tag, $sformatf("vec%0d partition", i), 32'(n), 32'(v[24]));
      if (v[7:0] != 8'd0) chk(tag, $sformatf("vec%0d latency", i), 32'(lat), 32'(v[7:0]));
      if (i == 5)  chk("R5", "0x10 still in SRAM", 32'(n), 32'd0);
      if (i == 14) chk("R6", "LRU kept 0x12", 32'(h), 32'd1);
      if (i == 16) chk("R7", "clean victims silent", 32'(wb_cnt), 32'd1);
    end
    chk("R7", "write-back count", 32'(wb_cnt), 32'd2);
    chk("R7", "mem[0x10]", 32'(mem[8'h10]), 32'h0000AAAA);
    chk("R7", "mem[0x30]", 32'(mem[8'h30]), 32'h0000CCCC);

    // R8: ready stays low through a long STT-RAM write hit
    do_op(1'b1, 8'h21, 1'b0, 16'hEEEE, 0, d, h, n, lat, br, hb);
    chk("R8", "ready low while busy", 32'(br), 32'd0);
    chk("R8", "long write latency", 32'(lat), 32'd13);

    // R9: response back-pressure
    do_op(1'b0, 8'h21, 1'b0, 16'h0000, 4, d, h, n, lat, br, hb);
    chk("R9", "response held", 32'(hb), 32'd0);
    chk("R9", "held data", 32'(d), 32'h0000EEEE);

    // R9: memory back-pressure on a miss
    mem_delay = 3;
    do_op(1'b0, 8'h40, 1'b0, 16'h0000, 0, d, h, n, lat, br, hb);
    chk("R9", "slow memory fill data", 32'(d), 32'h000040BF);
    chk("R2", "slow memory fill partition", 32'(n), 32'd0);
    mem_delay = 0;

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule